// File: doc/BRIEF.md
# Channel-Grouped Transmit Sample FIFO

This block buffers audio samples on their way from a processor to a serial audio shifter. The processor pushes 24-bit sample words through a data write port. The shifter pulls one word for each channel slot it sends. The storage is a word-organised RAM of `256 << SIZE_CODE` words. The RAM is divided into equal per-channel regions. The number of regions is the configured channel count rounded up to the next power of two. As a result, a three-channel stream gets the same per-channel depth as a four-channel stream, and the words of the fourth region go unused.

A control write can empty the FIFO and can enable a level-sensitive interrupt that asks for more data. The interrupt stays asserted while the FIFO is at most half full. A status word gives the fill level in frames rather than words. It also carries two sticky error flags: one for a write that was dropped because the FIFO was full, and one for a slot read that found the FIFO empty. A 16-bit sample is written left-justified, shifted up by 8 bits, so that it occupies the upper part of the 24 kept bits.

The channel count is treated as static while data is stored. Software changes it only when the FIFO is empty, for example right after a clear.

Top module: `chgrp_tx_fifo`

## Requirements
- R1: After reset, `status` is zero, `half_irq` is low and `slot_data` is zero.
- R2: Only bits 23:0 of a data write are stored. Samples leave on `slot_data` in the order they were written.
- R3: The FIFO accepts at most `((256 << SIZE_CODE) >> g) * ch` words, where g is 0 for 1 channel, 1 for 2 channels, 2 for 3–4 channels and 3 for 5–8 channels. A data write beyond that limit is dropped.
- R4: A `chan_cnt` of 0 is used as 1 channel. A `chan_cnt` above 8 is used as 8 channels.
- R5: `status[16:8]` holds the number of frames whose last word has been written minus the number of frames whose last word has been read. One frame is ch words. The value saturates at 511.
- R6: A control write with bit 0 set empties the FIFO, and the level becomes 0. A data write or a slot pop in the same cycle is ignored, and a pop in that cycle returns zero.
- R7: A data write while the FIFO is full sets the sticky overrun flag `status[4]`.
- R8: A slot pop while the FIFO is empty sets the sticky underrun flag `status[0]`, and `slot_data` becomes zero.
- R9: A status write clears each flag whose bit (4 or 0) in the written word is 0. Writing zero clears both flags. An error event in the same cycle takes priority over the clear.
- R10: `half_irq` is high exactly when bit 20 of the last control write was 1 and the stored word count is at most half of the R3 limit.
- R11: `slot_data` changes only in the cycle after a slot pop and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chan_cnt | input | 4 | Configured channel count, 1 to 8 |
| dat_wr | input | 1 | Data write strobe |
| dat_wdata | input | 32 | Data word; bits 23:0 are kept |
| ctl_wr | input | 1 | Control write strobe |
| ctl_wdata | input | 32 | Control word: bit 0 clears the FIFO, bit 20 enables the half interrupt |
| st_wr | input | 1 | Status write strobe (flag clear) |
| st_wdata | input | 32 | Status write word: bits 4 and 0 keep their flag when set |
| status | output | 32 | Bits 16:8 frame level, bit 4 overrun, bit 0 underrun |
| slot_pop | input | 1 | Serial side takes one word |
| slot_data | output | 24 | Word taken by the last pop |
| half_irq | output | 1 | Level request for more data |

## Verification
The hardest state to reach from the ports is the exact full boundary for non-power-of-two channel counts. For three channels, the limit is 192 words, not 256. Reaching it needs a long run of writes with few pops, followed by further writes that must be dropped. The bench runs epochs with a random channel count. Each epoch has a write-heavy phase that drives the FIFO into full and overrun, then a pop-heavy phase that drains it into underrun. Directed fills with channel counts 3, 0 and 12 count exactly how many words are accepted before the overrun flag rises.

// File: rtl/chgrp_pkg.sv
// Shared constants and helpers for the channel-grouped transmit FIFO.
// Assumes a base RAM size of 256 words and at most 8 channels.
package chgrp_pkg;
    localparam int BASE_WORDS  = 256;
    localparam int SAMPLE_W    = 24;
    localparam int CH_W        = 4;
    localparam int LVL_W       = 9;
    localparam int LVL_LSB     = 8;
    localparam int OVR_BIT     = 4;
    localparam int UND_BIT     = 0;
    localparam int CLR_BIT     = 0;
    localparam int HALF_EN_BIT = 20;

    // Map an out-of-range channel count into 1..8.
    function automatic logic [CH_W-1:0] clamp_ch(input logic [CH_W-1:0] c);
        if (c == '0)             return CH_W'(1);
        else if (c > CH_W'(8))   return CH_W'(8);
        else                     return c;
    endfunction

    // Number of halvings needed for the channel group to cover c channels.
    function automatic logic [1:0] grp_shift(input logic [CH_W-1:0] c);
        if (c <= CH_W'(1))      return 2'd0;
        else if (c == CH_W'(2)) return 2'd1;
        else if (c <= CH_W'(4)) return 2'd2;
        else                    return 2'd3;
    endfunction
endpackage

// File: rtl/chgrp_geom.sv
// Capacity calculator: from the channel count it derives the effective
// channel count, the usable word limit and the half-fill threshold.
// Assumes the RAM holds 2**AW words.
module chgrp_geom
    import chgrp_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic [CH_W-1:0] chan_cnt,
    output logic [CH_W-1:0] ch_eff,
    output logic [AW:0]     max_words,
    output logic [AW:0]     half_words
);
    localparam logic [AW:0] CAP = (AW+1)'(1) << AW;

    logic [AW:0] depth;

    // Per-channel depth times channel count gives the usable words.
    always_comb begin
        ch_eff     = clamp_ch(chan_cnt);
        depth      = CAP >> grp_shift(ch_eff);
        max_words  = depth * (AW+1)'(ch_eff);
        half_words = max_words >> 1;
    end
endmodule

// File: rtl/chgrp_ram.sv
// Word RAM with one write port and an asynchronous read port.
// Assumes the caller guards writes against overfill.
module chgrp_ram #(
    parameter int AW = 8,
    parameter int DW = 24
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [2**AW];

    // Store an accepted sample.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/chgrp_ctrl.sv
// Occupancy tracker: pointers, word count, frame count and sticky flags.
// Assumes ch_eff stays constant while the FIFO holds data.
module chgrp_ctrl
    import chgrp_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            push,
    input  logic            pop,
    input  logic [CH_W-1:0] ch_eff,
    input  logic [AW:0]     max_words,
    input  logic            flag_wr,
    input  logic            keep_ovr,
    input  logic            keep_und,
    output logic            push_ok,
    output logic            pop_ok,
    output logic [AW-1:0]   waddr,
    output logic [AW-1:0]   raddr,
    output logic [AW:0]     words,
    output logic [AW:0]     frames,
    output logic            ovr,
    output logic            und
);
    logic            full, empty, wdone, rdone;
    logic [CH_W-1:0] wslot, rslot;

    assign full    = (words >= max_words);
    assign empty   = (words == '0);
    assign push_ok = push & ~clr & ~full;
    assign pop_ok  = pop  & ~clr & ~empty;
    assign wdone   = push_ok & (wslot == ch_eff - CH_W'(1));
    assign rdone   = pop_ok  & (rslot == ch_eff - CH_W'(1));

    // Advance pointers, slot positions and counts; clear empties them all.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            waddr  <= '0;
            raddr  <= '0;
            words  <= '0;
            frames <= '0;
            wslot  <= '0;
            rslot  <= '0;
        end else begin
            if (push_ok) begin
                waddr <= waddr + AW'(1);
                wslot <= wdone ? '0 : wslot + CH_W'(1);
            end
            if (pop_ok) begin
                raddr <= raddr + AW'(1);
                rslot <= rdone ? '0 : rslot + CH_W'(1);
            end
            words  <= words  + (AW+1)'(push_ok) - (AW+1)'(pop_ok);
            frames <= frames + (AW+1)'(wdone)   - (AW+1)'(rdone);
        end
    end

    // Sticky error flags: a new event wins over a clear by status write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovr <= 1'b0;
            und <= 1'b0;
        end else begin
            ovr <= (ovr & ~(flag_wr & ~keep_ovr)) | (push & ~clr & full);
            und <= (und & ~(flag_wr & ~keep_und)) | (pop  & ~clr & empty);
        end
    end
endmodule

// File: rtl/chgrp_tx_fifo.sv
// Transmit sample FIFO with channel-grouped capacity. The processor writes
// 24-bit words; the serial side pops one word per channel slot.
// Assumes chan_cnt changes only while the FIFO is empty.
module chgrp_tx_fifo
    import chgrp_pkg::*;
#(
    parameter int SIZE_CODE = 0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [CH_W-1:0]     chan_cnt,
    input  logic                dat_wr,
    input  logic [31:0]         dat_wdata,
    input  logic                ctl_wr,
    input  logic [31:0]         ctl_wdata,
    input  logic                st_wr,
    input  logic [31:0]         st_wdata,
    output logic [31:0]         status,
    input  logic                slot_pop,
    output logic [SAMPLE_W-1:0] slot_data,
    output logic                half_irq
);
    localparam int AW = $clog2(BASE_WORDS) + SIZE_CODE;

    logic [CH_W-1:0]     ch_eff;
    logic [AW:0]         max_words, half_words, words, frames;
    logic [AW-1:0]       waddr, raddr;
    logic [SAMPLE_W-1:0] rdata;
    logic                clr, push_ok, pop_ok, ovr, und, half_en;
    logic [LVL_W-1:0]    level;

    assign clr = ctl_wr & ctl_wdata[CLR_BIT];

    chgrp_geom #(.AW(AW)) u_geom (
        .chan_cnt   (chan_cnt),
        .ch_eff     (ch_eff),
        .max_words  (max_words),
        .half_words (half_words)
    );

    chgrp_ctrl #(.AW(AW)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .push      (dat_wr),
        .pop       (slot_pop),
        .ch_eff    (ch_eff),
        .max_words (max_words),
        .flag_wr   (st_wr),
        .keep_ovr  (st_wdata[OVR_BIT]),
        .keep_und  (st_wdata[UND_BIT]),
        .push_ok   (push_ok),
        .pop_ok    (pop_ok),
        .waddr     (waddr),
        .raddr     (raddr),
        .words     (words),
        .frames    (frames),
        .ovr       (ovr),
        .und       (und)
    );

    chgrp_ram #(.AW(AW), .DW(SAMPLE_W)) u_ram (
        .clk   (clk),
        .we    (push_ok),
        .waddr (waddr),
        .wdata (dat_wdata[SAMPLE_W-1:0]),
        .raddr (raddr),
        .rdata (rdata)
    );

    // Hold the interrupt enable from the last control write.
    always_ff @(posedge clk) begin
        if (!rst_n)      half_en <= 1'b0;
        else if (ctl_wr) half_en <= ctl_wdata[HALF_EN_BIT];
    end

    // Register the popped word; an empty or clearing pop yields zero.
    always_ff @(posedge clk) begin
        if (!rst_n)        slot_data <= '0;
        else if (slot_pop) slot_data <= pop_ok ? rdata : '0;
    end

    // Assemble the status word with a saturated frame level.
    always_comb begin
        level = (frames > (AW+1)'((1 << LVL_W) - 1)) ? '1 : LVL_W'(frames);
        status = '0;
        status[LVL_LSB +: LVL_W] = level;
        status[OVR_BIT]          = ovr;
        status[UND_BIT]          = und;
    end

    assign half_irq = half_en & (words <= half_words);
endmodule

// File: rtl/chgrp_tx_fifo_chk.sv
// Property checker for the channel-grouped transmit FIFO, bound to the top.
// Assumes chan_cnt changes only while the FIFO is empty.
module chgrp_tx_fifo_chk #(
    parameter int AW = 8
) (
    input logic        clk,
    input logic        rst_n,
    input logic        dat_wr,
    input logic        ctl_wr,
    input logic [31:0] ctl_wdata,
    input logic        st_wr,
    input logic [31:0] st_wdata,
    input logic        slot_pop,
    input logic [23:0] slot_data,
    input logic [31:0] status,
    input logic        half_irq,
    input logic [AW:0] words,
    input logic [AW:0] max_words
);
    logic clr_c;
    assign clr_c = ctl_wr & ctl_wdata[0];

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        words <= max_words);

    p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_c |=> (words == $past(words) || words == $past(words) + 1'b1
                    || words + 1'b1 == $past(words)));

    p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clr_c |=> (status[16:8] == 9'd0 && words == '0));

    p_overrun_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_wr && !clr_c && words == max_words) |=> status[4]);

    p_underrun_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_pop && !clr_c && words == '0) |=> (status[0] && slot_data == '0));

    p_flag_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_wr && st_wdata == '0 && !dat_wr && !slot_pop) |=> (!status[4] && !status[0]));

    p_irq_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && !ctl_wdata[20]) |=> !half_irq);

    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_pop |=> $stable(slot_data));
endmodule

bind chgrp_tx_fifo chgrp_tx_fifo_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .dat_wr    (dat_wr),
    .ctl_wr    (ctl_wr),
    .ctl_wdata (ctl_wdata),
    .st_wr     (st_wr),
    .st_wdata  (st_wdata),
    .slot_pop  (slot_pop),
    .slot_data (slot_data),
    .status    (status),
    .half_irq  (half_irq),
    .words     (words),
    .max_words (max_words)
);

// File: tb/chgrp_tx_fifo_tb.sv
`timescale 1ns/1ps
module chgrp_tx_fifo_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [3:0]  chan_cnt;
    logic        dat_wr, ctl_wr, st_wr, slot_pop, half_irq;
    logic [31:0] dat_wdata, ctl_wdata, st_wdata, status;
    logic [23:0] slot_data;

    int errors = 0;
    int checks = 0;

    always #2.5 clk = ~clk;

    chgrp_tx_fifo u_dut (
        .clk(clk), .rst_n(rst_n), .chan_cnt(chan_cnt),
        .dat_wr(dat_wr), .dat_wdata(dat_wdata),
        .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .st_wr(st_wr), .st_wdata(st_wdata), .status(status),
        .slot_pop(slot_pop), .slot_data(slot_data), .half_irq(half_irq)
    );

    // Reference model state
    logic [23:0] mq[$];
    bit          m_ovr, m_und, m_en;
    int          m_fw, m_fr, m_ws, m_rs, m_ch;
    logic [23:0] m_sd;

    function automatic int eff_ch(int c);
        if (c == 0) return 1;
        if (c > 8)  return 8;
        return c;
    endfunction

    function automatic int cap_words(int c);
        int g;
        g = (c <= 1) ? 0 : (c == 2) ? 1 : (c <= 4) ? 2 : 3;
        return (256 >> g) * c;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic set_ch(int c);
        chan_cnt = 4'(c);
        m_ch = eff_ch(c);
    endtask

    // One clock: drive inputs, update model, then compare outputs.
    task automatic cyc(bit dw, logic [31:0] wd, bit pp, bit cw, logic [31:0] cd,
                       bit sw, logic [31:0] sd);
        bit clr, full, empty;
        int lvl;
        dat_wr = dw; dat_wdata = wd; slot_pop = pp;
        ctl_wr = cw; ctl_wdata = cd; st_wr = sw; st_wdata = sd;
        clr   = cw && cd[0];
        full  = mq.size() >= cap_words(m_ch);
        empty = mq.size() == 0;
        if (sw) begin
            if (!sd[4]) m_ovr = 0;
            if (!sd[0]) m_und = 0;
        end
        if (clr) begin
            mq.delete(); m_fw = 0; m_fr = 0; m_ws = 0; m_rs = 0;
            if (pp) m_sd = '0;
        end else begin
            if (pp) begin
                if (!empty) begin
                    m_sd = mq.pop_front();
                    if (m_rs == m_ch - 1) begin m_rs = 0; m_fr++; end else m_rs++;
                end else begin
                    m_sd = '0; m_und = 1;
                end
            end
            if (dw) begin
                if (!full) begin
                    mq.push_back(wd[23:0]);
                    if (m_ws == m_ch - 1) begin m_ws = 0; m_fw++; end else m_ws++;
                end else m_ovr = 1;
            end
        end
        if (cw) m_en = cd[20];
        @(posedge clk);
        #1;
        dat_wr = 0; slot_pop = 0; ctl_wr = 0; st_wr = 0;
        lvl = m_fw - m_fr;
        if (lvl > 511) lvl = 511;
        check("R5 level",     32'(status[16:8]), 32'(lvl));
        check("R7 overrun",   32'(status[4]),    32'(m_ovr));
        check("R8 underrun",  32'(status[0]),    32'(m_und));
        check("R10 half_irq", 32'(half_irq),
              32'(m_en && (mq.size() <= cap_words(m_ch) / 2)));
        check("R2 R11 slot_data", 32'(slot_data), 32'(m_sd));
    endtask

    task automatic do_clear(logic en);
        logic [31:0] c;
        c = '0; c[0] = 1'b1; c[20] = en;
        cyc(0, 0, 0, 1, c, 0, 0);
    endtask

    // Fill until the FIFO drops a write; return the number accepted.
    task automatic fill_count(output int n);
        n = 0;
        for (int i = 0; i < 300; i++) begin
            cyc(1, $urandom, 0, 0, 0, 0, 0);
            if (status[4]) break;
            n++;
        end
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int n;
        int c;
        logic [31:0] w;
        void'($urandom(32'd1234));
        rst_n = 0; dat_wr = 0; ctl_wr = 0; st_wr = 0; slot_pop = 0;
        dat_wdata = 0; ctl_wdata = 0; st_wdata = 0;
        set_ch(2);
        mq.delete(); m_ovr = 0; m_und = 0; m_en = 0;
        m_fw = 0; m_fr = 0; m_ws = 0; m_rs = 0; m_sd = '0;
        repeat (3) @(posedge clk);
        #1;
        check("R1 status", status, 32'h0);
        check("R1 half_irq", 32'(half_irq), 32'h0);
        check("R1 slot_data", 32'(slot_data), 32'h0);
        rst_n = 1;
        @(negedge clk);

        // R2: upper bits dropped, order kept, 16-bit sample left-justified
        cyc(1, 32'hFFAB_CDEF, 0, 0, 0, 0, 0);
        cyc(1, 32'h0012_3400, 0, 0, 0, 0, 0);
        cyc(0, 0, 1, 0, 0, 0, 0);
        check("R2 first word", 32'(slot_data), 32'h00AB_CDEF);
        cyc(0, 0, 1, 0, 0, 0, 0);
        check("R2 second word", 32'(slot_data), 32'h0012_3400);

        // R8: pop on empty gives zero and sets underrun
        cyc(0, 0, 1, 0, 0, 0, 0);
        check("R8 empty pop", {slot_data, 7'd0, status[0]}, 32'h1);

        // R9: keep underrun by writing bit0=1, then clear with zero
        cyc(0, 0, 0, 0, 0, 1, 32'h1);
        check("R9 keep", 32'(status[0]), 32'h1);
        cyc(0, 0, 0, 0, 0, 1, 32'h0);
        check("R9 clear", 32'(status[0]), 32'h0);

        // R3: three channels give 192 words; R7 overrun
        do_clear(1'b1);
        set_ch(3);
        fill_count(n);
        check("R3 capacity 3ch", 32'(n), 32'd192);
        check("R7 overrun set", 32'(status[4]), 32'h1);
        check("R5 level 3ch", 32'(status[16:8]), 32'd64);

        // R6: clear with concurrent write and pop
        cyc(1, 32'h55, 1, 1, 32'h1, 0, 0);
        check("R6 cleared level", 32'(status[16:8]), 32'd0);
        check("R6 pop during clear", 32'(slot_data), 32'd0);
        cyc(0, 0, 1, 0, 0, 0, 0);
        check("R6 empty after clear", 32'(status[0]), 32'h1);

        // R4: channel count 0 acts as 1, 12 acts as 8
        cyc(0, 0, 0, 0, 0, 1, 32'h0);
        set_ch(0);
        fill_count(n);
        check("R4 count 0 as 1ch", 32'(n), 32'd256);
        do_clear(1'b0);
        cyc(0, 0, 0, 0, 0, 1, 32'h0);
        set_ch(12);
        fill_count(n);
        check("R4 count 12 as 8ch", 32'(n), 32'd256);
        check("R5 level 8ch", 32'(status[16:8]), 32'd32);

        // Random epochs: write-heavy then pop-heavy
        for (int e = 0; e < 8; e++) begin
            do_clear(1'($urandom_range(0, 1)));
            c = $urandom_range(0, 10);
            set_ch(c);
            for (int i = 0; i < 1500; i++) begin
                bit dw, pp, sw, cw;
                logic [31:0] cd;
                dw = (i < 700) ? ($urandom_range(0, 9) < 8) : ($urandom_range(0, 9) < 2);
                pp = (i < 700) ? ($urandom_range(0, 9) < 2) : ($urandom_range(0, 9) < 8);
                sw = ($urandom_range(0, 49) == 0);
                cw = ($urandom_range(0, 99) == 0);
                cd = $urandom;
                cd[0] = 1'b0;
                w = $urandom;
                cyc(dw, w, pp, cw, cd, sw, $urandom);
            end
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule